// File: doc/BRIEF.md
# Interrupt Pending and Enable State Block

This block turns raw interrupt request lines and software register writes into per-interrupt, per-CPU pending and enable state. Two kinds of source feed it. Shared external lines each map to one interrupt ID above the private range and are routed to a programmable set of CPUs. Private lines belong to one CPU each and map to the low IDs. For every ID the block keeps a level record per CPU, enable bits, a two-bit configuration (edge/level and a one-of-N handling flag) and, for shared IDs, a target CPU mask.

Software drives a single write port. One cycle carries a write kind, the writing CPU, a byte index and one data byte. Enable and pending writes cover eight IDs per byte and configuration writes cover four. The pending and enable vectors go straight to a downstream priority selector. The one-of-N flags are brought out for the acknowledge logic.

Level-configured interrupts only become pending while enabled, and they become pending again when enabled with the line still high. Edge-configured interrupts latch on every rising level whatever their enable state.

Top module: `irq_pend_core`

## Requirements
- R1: After reset, IDs 0 to 15 are enabled for every CPU. All other enable bits, all pending bits, all configuration fields, all target masks and all level records are zero.
- R2: Shared line n acts on ID 32+n for the CPUs in that ID's target mask. Private line bit c*32+k acts on ID k for CPU c only. A line change reaches pend_o on the third rising clock edge after it is applied: two synchroniser stages, then the state register.
- R3: A rising level on a level-configured ID sets pending only if the ID is enabled. For shared IDs this means enabled on any CPU; for private IDs it means enabled on the line's CPU.
- R4: A rising level on an edge-configured ID sets pending even when disabled. A line that is held high does not set pending again after pending has been cleared.
- R5: A falling line updates only the level record. Pending bits stay as they are.
- R6: A set-enable write to a level-configured ID whose line is high sets pending: for a shared ID on its target CPUs, for a private ID on the writing CPU. This includes a line that rises in the same cycle as the write.
- R7: Set-enable (kind 0) and clear-enable (kind 1) for IDs below 32 touch only the writing CPU's bit. For IDs 32 and up they touch every CPU's bit, so enable bits of a shared ID are always equal across CPUs.
- R8: Set-pending (kind 2) marks a private ID pending for the writing CPU and a shared ID pending for its target mask.
- R9: Clear-pending (kind 3) clears the selected IDs on every CPU, private IDs included. A rising level that would set pending in the same cycle wins over the clear.
- R10: A configuration write (kind 4) with byte index g sets IDs 4g to 4g+3. Bits [2j] hold the one-of-N flag and bits [2j+1] the edge flag of ID 4g+j. Writes to IDs below 32 are ignored, so those IDs stay level-configured with the flag at zero.
- R11: A target write (kind 5) uses the byte index as the ID and the low NCPU data bits as its CPU mask. It only has an effect on shared IDs.
- R12: For kinds 0 to 3, bit b of byte index g addresses ID 8g+b. An index with no ID behind it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq_i | input | 32 | Shared interrupt lines, asynchronous |
| priv_irq_i | input | 64 | Private lines, bit c*32+k is CPU c, ID k |
| wr_en_i | input | 1 | Write strobe |
| wr_cpu_i | input | 1 | Index of the writing CPU |
| wr_kind_i | input | 3 | 0 set-enable, 1 clear-enable, 2 set-pending, 3 clear-pending, 4 configuration, 5 target |
| wr_idx_i | input | 6 | Byte index (kinds 0-4) or ID (kind 5) |
| wr_data_i | input | 8 | Write data byte |
| pend_o | output | 128 | Pending, bit id*2+c |
| en_o | output | 128 | Enable, bit id*2+c |
| one_of_n_o | output | 64 | One-of-N handling flag per ID |

## Verification
Two pairs of events can land on the same edge: a synchronised rising level meeting a clear-pending write, and a rising level meeting a set-enable write. The bench sets the line two cycles before it issues the write, so that the synchronised edge and the write arrive at the state register together. For the first pair, pending must survive the clear. For the second, a level interrupt that was disabled must come out pending on its target CPU. Both outcomes are read from pend_o half a cycle after that edge.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

   typedef enum logic [2:0] {
      WK_SET_EN   = 3'd0,
      WK_CLR_EN   = 3'd1,
      WK_SET_PEND = 3'd2,
      WK_CLR_PEND = 3'd3,
      WK_CONFIG   = 3'd4,
      WK_TARGET   = 3'd5
   } wr_kind_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync needs at least two stages");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stage_q[s] <= '0;
         else        stage_q[s] <= (s == 0) ? d_i : stage_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/irq_pend_slot.sv
module irq_pend_slot #(
   parameter int NCPU     = 2,
   parameter bit PRIVATE  = 1'b0,
   parameter bit RESET_EN = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCPU-1:0] line_i,
   input  logic [NCPU-1:0] wr_oh_i,
   input  logic            set_en_i,
   input  logic            clr_en_i,
   input  logic            set_pend_i,
   input  logic            clr_pend_i,
   input  logic            cfg_we_i,
   input  logic [1:0]      cfg_i,
   input  logic            tgt_we_i,
   input  logic [NCPU-1:0] tgt_i,
   output logic [NCPU-1:0] pend_o,
   output logic [NCPU-1:0] en_o,
   output logic            one_of_n_o
);

   localparam logic [NCPU-1:0] TGT_RST = PRIVATE ? '1 : '0;

   logic [NCPU-1:0] lvl_q, en_q, pend_q, tgt_q;
   logic            trig_q, model_q;

   logic [NCPU-1:0] rise, in_set, bank_mask, lvl_mask, sw_mask;
   logic [NCPU-1:0] en_n, pend_n;

   assign rise = line_i & ~lvl_q;

   // Private IDs: everything per CPU. Shared IDs: one event drives the target mask.
   if (PRIVATE) begin : g_private
      assign in_set    = rise & tgt_q & ({NCPU{trig_q}} | en_q);
      assign bank_mask = wr_oh_i;
      assign lvl_mask  = wr_oh_i & line_i & tgt_q;
      assign sw_mask   = wr_oh_i & tgt_q;
   end else begin : g_shared
      assign in_set    = ((|rise) && (trig_q || (|en_q))) ? tgt_q : '0;
      assign bank_mask = '1;
      assign lvl_mask  = (|line_i) ? tgt_q : '0;
      assign sw_mask   = tgt_q;
   end

   always_comb begin
      en_n = en_q;
      if (set_en_i) en_n = en_n | bank_mask;
      if (clr_en_i) en_n = en_n & ~bank_mask;

      // The clear is applied first, so sets arriving in the same cycle survive it.
      pend_n = clr_pend_i ? '0 : pend_q;
      pend_n = pend_n | in_set;
      if (set_en_i && !trig_q) pend_n = pend_n | lvl_mask;
      if (set_pend_i)          pend_n = pend_n | sw_mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q   <= '0;
         en_q    <= {NCPU{RESET_EN}};
         pend_q  <= '0;
         tgt_q   <= TGT_RST;
         trig_q  <= 1'b0;
         model_q <= 1'b0;
      end else begin
         lvl_q  <= line_i;
         en_q   <= en_n;
         pend_q <= pend_n;
         if (cfg_we_i && !PRIVATE) begin
            model_q <= cfg_i[0];
            trig_q  <= cfg_i[1];
         end
         if (tgt_we_i && !PRIVATE) tgt_q <= tgt_i;
      end
   end

   assign pend_o     = pend_q;
   assign en_o       = en_q;
   assign one_of_n_o = model_q;

endmodule

// File: rtl/irq_pend_core.sv
module irq_pend_core
   import irq_pend_pkg::*;
#(
   parameter int NUM_IDS     = 64,
   parameter int NCPU        = 2,
   parameter int PRIV_IDS    = 32,
   parameter int RST_EN_IDS  = 16,
   parameter int SYNC_STAGES = 2,
   localparam int NUM_EXT    = NUM_IDS - PRIV_IDS,
   localparam int CPU_W      = (NCPU > 1) ? $clog2(NCPU) : 1,
   localparam int IDX_W      = $clog2(NUM_IDS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_EXT-1:0]       ext_irq_i,
   input  logic [NCPU*PRIV_IDS-1:0] priv_irq_i,
   input  logic                     wr_en_i,
   input  logic [CPU_W-1:0]         wr_cpu_i,
   input  logic [2:0]               wr_kind_i,
   input  logic [IDX_W-1:0]         wr_idx_i,
   input  logic [7:0]               wr_data_i,
   output logic [NUM_IDS*NCPU-1:0]  pend_o,
   output logic [NUM_IDS*NCPU-1:0]  en_o,
   output logic [NUM_IDS-1:0]       one_of_n_o
);

   if (NUM_IDS % 8 != 0)        begin : g_chk_ids  $error("NUM_IDS must be a multiple of 8"); end
   if (NUM_IDS <= PRIV_IDS)     begin : g_chk_ext  $error("no shared IDs left"); end
   if (NCPU < 1 || NCPU > 8)    begin : g_chk_cpu  $error("NCPU must be 1 to 8"); end
   if (RST_EN_IDS > PRIV_IDS)   begin : g_chk_rst  $error("reset-enabled IDs must be private"); end

   logic [NUM_EXT-1:0]       ext_s;
   logic [NCPU*PRIV_IDS-1:0] priv_s;
   logic [NCPU-1:0]          wr_oh;
   wr_kind_e                 kind;

   irq_sync #(.WIDTH(NUM_EXT), .STAGES(SYNC_STAGES)) u_sync_ext (
      .clk(clk), .rst_n(rst_n), .d_i(ext_irq_i), .q_o(ext_s));

   irq_sync #(.WIDTH(NCPU*PRIV_IDS), .STAGES(SYNC_STAGES)) u_sync_priv (
      .clk(clk), .rst_n(rst_n), .d_i(priv_irq_i), .q_o(priv_s));

   assign wr_oh = NCPU'(1) << wr_cpu_i;
   assign kind  = wr_kind_e'(wr_kind_i);

   for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
      localparam int  G8 = i / 8;
      localparam int  B8 = i % 8;
      localparam int  G4 = i / 4;
      localparam int  B4 = i % 4;
      localparam bit  IS_PRIV = (i < PRIV_IDS);

      logic [NCPU-1:0] line;
      logic            hit8, set_en, clr_en, set_pend, clr_pend, cfg_we, tgt_we;

      if (IS_PRIV) begin : g_pl
         for (genvar c = 0; c < NCPU; c++) begin : g_c
            assign line[c] = priv_s[c*PRIV_IDS + i];
         end
      end else begin : g_sl
         assign line = {NCPU{ext_s[i-PRIV_IDS]}};
      end

      assign hit8     = wr_en_i && (wr_idx_i == IDX_W'(G8)) && wr_data_i[B8];
      assign set_en   = hit8 && (kind == WK_SET_EN);
      assign clr_en   = hit8 && (kind == WK_CLR_EN);
      assign set_pend = hit8 && (kind == WK_SET_PEND);
      assign clr_pend = hit8 && (kind == WK_CLR_PEND);
      assign cfg_we   = wr_en_i && (kind == WK_CONFIG) && (wr_idx_i == IDX_W'(G4));
      assign tgt_we   = wr_en_i && (kind == WK_TARGET) && (wr_idx_i == IDX_W'(i));

      irq_pend_slot #(
         .NCPU(NCPU), .PRIVATE(IS_PRIV), .RESET_EN(i < RST_EN_IDS)
      ) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .line_i    (line),
         .wr_oh_i   (wr_oh),
         .set_en_i  (set_en),
         .clr_en_i  (clr_en),
         .set_pend_i(set_pend),
         .clr_pend_i(clr_pend),
         .cfg_we_i  (cfg_we),
         .cfg_i     (wr_data_i[2*B4 +: 2]),
         .tgt_we_i  (tgt_we),
         .tgt_i     (wr_data_i[NCPU-1:0]),
         .pend_o    (pend_o[i*NCPU +: NCPU]),
         .en_o      (en_o[i*NCPU +: NCPU]),
         .one_of_n_o(one_of_n_o[i])
      );
   end

endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk #(
   parameter int NUM_IDS  = 64,
   parameter int NCPU     = 2,
   parameter int PRIV_IDS = 32
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en_i,
   input logic [2:0]              wr_kind_i,
   input logic [NUM_IDS*NCPU-1:0] pend_o,
   input logic [NUM_IDS*NCPU-1:0] en_o,
   input logic [NUM_IDS-1:0]      one_of_n_o
);

   // R9 / R5: a pending bit may only drop after a clear-pending write
   a_r9_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(pend_o) & ~pend_o)) |-> $past(wr_en_i && wr_kind_i == 3'd3));

   // R7: enable bits move only on enable writes
   a_r7_en_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (en_o != $past(en_o)) |-> $past(wr_en_i && (wr_kind_i == 3'd0 || wr_kind_i == 3'd1)));

   // R10: the one-of-N flags move only on configuration writes
   a_r10_mode_needs_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      (one_of_n_o != $past(one_of_n_o)) |-> $past(wr_en_i && wr_kind_i == 3'd4));

   // R7: shared IDs keep identical enable bits on all CPUs
   for (genvar i = PRIV_IDS; i < NUM_IDS; i++) begin : g_sh
      a_r7_shared_uniform: assert property (@(posedge clk) disable iff (!rst_n)
         (en_o[i*NCPU +: NCPU] == '0) || (en_o[i*NCPU +: NCPU] == '1));
   end

endmodule

bind irq_pend_core irq_pend_chk #(
   .NUM_IDS(NUM_IDS), .NCPU(NCPU), .PRIV_IDS(PRIV_IDS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_kind_i(wr_kind_i),
   .pend_o(pend_o), .en_o(en_o), .one_of_n_o(one_of_n_o)
);

// File: tb/sim_irq_pend_core.sv
`timescale 1ns/1ps
module sim_irq_pend_core;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [31:0]  ext = '0;
   logic [63:0]  priv = '0;
   logic         wr_en = 1'b0;
   logic [0:0]   wr_cpu = '0;
   logic [2:0]   wr_kind = '0;
   logic [5:0]   wr_idx = '0;
   logic [7:0]   wr_data = '0;
   logic [127:0] pend, en;
   logic [63:0]  oon;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_pend_core u0 (
      .clk(clk), .rst_n(rst_n), .ext_irq_i(ext), .priv_irq_i(priv),
      .wr_en_i(wr_en), .wr_cpu_i(wr_cpu), .wr_kind_i(wr_kind),
      .wr_idx_i(wr_idx), .wr_data_i(wr_data),
      .pend_o(pend), .en_o(en), .one_of_n_o(oon));

   task automatic cyc(input int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic wr(input logic [2:0] k, input int cpu, input int idx, input logic [7:0] d);
      wr_en = 1'b1; wr_kind = k; wr_cpu = cpu[0:0]; wr_idx = idx[5:0]; wr_data = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog got hang exp finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [127:0] e;
      logic [127:0] en_snap;
      @(negedge clk);
      cyc(3);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 enable", en, {96'd0, 32'hFFFF_FFFF});
      chk("R1 pending", pend, '0);
      chk("R1 mode", {64'd0, oon}, '0);

      // R11 targets id%4, R10 all shared IDs edge
      for (int id = 32; id < 64; id++) wr(3'd5, 0, id, 8'(id % 4));
      for (int g = 8; g < 16; g++) wr(3'd4, 0, g, 8'hAA);
      chk("R10 edge only, mode clear", {64'd0, oon}, '0);

      // R2 R4 edge pends while disabled, on the target mask
      e = '0;
      for (int id = 32; id < 64; id++) e[id*2 +: 2] = 2'(id % 4);
      ext = '1; cyc(3);
      chk("R2 R4 R11 shared edge sweep", pend, e);

      // R5 falling keeps pending
      ext = '0; cyc(3);
      chk("R5 fall keeps pend", pend, e);

      // R9 clear
      for (int g = 4; g < 8; g++) wr(3'd3, 0, g, 8'hFF);
      chk("R9 shared clear", pend, '0);

      // R4 re-raise pends, held level does not re-pend
      ext = '1; cyc(3);
      chk("R4 second rise", pend, e);
      for (int g = 4; g < 8; g++) wr(3'd3, 1, g, 8'hFF);
      cyc(3);
      chk("R4 held no repend", pend, '0);
      ext = '0; cyc(3);

      // R3 level disabled
      wr(3'd4, 0, 8, 8'h00); wr(3'd4, 0, 9, 8'h00);
      ext[7:0] = 8'hFF; cyc(3);
      chk("R3 level disabled", pend, '0);

      // R6 R7 set-enable with line high
      wr(3'd0, 0, 4, 8'h0E);
      chk("R6 enable pends", {120'd0, pend[71:64]}, {120'd0, 8'hE4});
      chk("R7 shared enable all cpus", {120'd0, en[71:64]}, {120'd0, 8'hFC});

      // R3 enabled rise
      wr(3'd3, 0, 4, 8'h0E);
      chk("R9 level clear", pend, '0);
      ext[7:0] = '0; cyc(3);
      ext[7:0] = 8'hFF; cyc(3);
      chk("R3 enabled rise", {120'd0, pend[71:64]}, {120'd0, 8'hE4});
      wr(3'd3, 0, 4, 8'hFF);

      // R7 banking
      wr(3'd0, 1, 2, 8'h01);
      chk("R7 private set bank", {126'd0, en[33:32]}, {126'd0, 2'b10});
      wr(3'd1, 0, 0, 8'h01);
      chk("R7 private clear bank", {126'd0, en[1:0]}, {126'd0, 2'b10});
      wr(3'd1, 1, 4, 8'h02);
      chk("R7 shared clear all", {124'd0, en[71:68], en[67:66]}, {124'd0, 4'hF, 2'b00});

      // R2 private routing
      priv[48] = 1'b1; priv[16] = 1'b1; cyc(3);
      chk("R2 private routing", {126'd0, pend[33:32]}, {126'd0, 2'b10});
      wr(3'd3, 0, 2, 8'h01);
      chk("R9 private cleared from other cpu", {126'd0, pend[33:32]}, '0);

      // R8 set-pending
      wr(3'd2, 1, 0, 8'h02);
      chk("R8 private to writer", {126'd0, pend[3:2]}, {126'd0, 2'b10});
      wr(3'd2, 0, 5, 8'h08);
      chk("R8 shared to target", {126'd0, pend[87:86]}, {126'd0, 2'b11});

      // R10 private config ignored
      wr(3'd4, 0, 5, 8'hFF);
      priv[20] = 1'b1; cyc(3);
      chk("R10 private stays level", {126'd0, pend[41:40]}, '0);
      wr(3'd4, 0, 12, 8'h55);
      chk("R10 mode bits", {64'd0, oon}, {64'd0, 64'h000F_0000_0000_0000});

      // R9 concurrent rise beats clear (ID53, target cpu0, edge)
      wr(3'd4, 0, 13, 8'h0A);
      wr(3'd2, 0, 6, 8'h20);
      chk("R8 preset id53", {126'd0, pend[107:106]}, {126'd0, 2'b01});
      ext[21] = 1'b1; cyc(2);
      wr(3'd3, 0, 6, 8'h20);
      chk("R9 rise wins over clear", {126'd0, pend[107:106]}, {126'd0, 2'b01});

      // R6 concurrent rise and set-enable (ID54, target cpu1, level)
      ext[22] = 1'b1; cyc(2);
      wr(3'd0, 0, 6, 8'h40);
      chk("R6 same-cycle enable", {126'd0, pend[109:108]}, {126'd0, 2'b10});

      // R12 out-of-range byte index
      en_snap = en;
      wr(3'd0, 0, 8, 8'hFF);
      chk("R12 index ignored", en, en_snap);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule